// File: doc/BRIEF.md
# Ratio-Programmable Pulse-Width Modulator

This block drives a single PWM output. Both its high time and its period length are runtime settings counted in system clocks. The duty ratio is therefore the quotient of two programmable integers rather than a fraction of a fixed power-of-two period.

Moving the period by one count between otherwise equal settings gives ratio steps much finer than 1/period. For example, a high time of 50 gives exactly one half over 100 clocks and about 0.495 over 101 clocks. The price is that the output frequency shifts whenever the period setting changes.

Software presents a high-time value and a period value together with a one-clock load strobe. The block holds them in a staging pair and moves them into the running pair only at a period boundary, so a period never mixes old and new settings. A one-clock marker flags the first cycle of every period. The settings path is a plain strobe: there is no valid/ready handshake and no back-pressure, and a load is always accepted on the clock it is seen.

Top module: `pwm_ratio_gen`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `pwm_o` low and `period_o` low. After reset, the running high time is 0 and the running period is 1 clock, and this holds until the first load.
- R2: With a running period value P (P ≥ 2), each period lasts exactly P clocks. `period_o` is high only in the first cycle of each period.
- R3: Within a period, `pwm_o` is high in cycles 0 to H-1 and low in the remaining cycles, where H is the running high time and cycles are numbered from 0. H = 0 gives a low level for the whole period. H ≥ P gives a high level for the whole period.
- R4: A period value of 0 or 1 is treated as a one-clock period. `period_o` is then high in every cycle, and `pwm_o` holds the constant level (H ≠ 0).
- R5: A load captures `duty_i` and `period_i` into the staging pair. A load made in any cycle except the last cycle of a period leaves the current period's length and waveform unchanged. The new values first apply in the period that starts at the next boundary.
- R6: A load made in the last cycle of a period applies to the period that starts on the very next cycle.
- R7: When several loads occur before a boundary, only the most recent one takes effect.
- R8: Values of `duty_i` and `period_i` presented while `load_i` is low have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | One-clock strobe that captures `duty_i` and `period_i` |
| duty_i | input | CW (8) | High time in clocks |
| period_i | input | CW (8) | Period length in clocks (0 is treated as 1) |
| pwm_o | output | 1 | PWM waveform |
| period_o | output | 1 | High in the first cycle of each period |

## Verification
The bench targets several corner cases:
- **Empty and full duty.** A high time of zero and a high time at or above the period catch a comparator with an off-by-one edge, which would leak a single high or low cycle.
- **Zero period.** A zero period catches a design that fails to normalise it, which would count through all 256 states instead of toggling every clock.
- **Mid-period load.** A load in the middle of a long period catches an unbuffered design, which would truncate the running period or change its waveform.
- **Load on the wrap cycle.** A load on the wrap cycle catches a design that loses or delays the setting by a full period.
- **Back-to-back loads.** Two loads before one boundary catch a design that keeps the first value rather than the last.
- **Idle inputs.** Values presented without the strobe must leave the output untouched.

// File: rtl/pwm_ratio_pkg.sv
package pwm_ratio_pkg;

  localparam int unsigned PWM_CW_DEFAULT = 8;

  // Classification of the running setting, used by the output stage.
  typedef enum logic [1:0] {
    LVL_LOW  = 2'd0,
    LVL_MOD  = 2'd1,
    LVL_HIGH = 2'd2
  } pwm_level_e;

endpackage

// File: rtl/pwm_cfg_bank.sv
module pwm_cfg_bank #(
  parameter int unsigned CW = pwm_ratio_pkg::PWM_CW_DEFAULT
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [CW-1:0] duty_i,
  input  logic [CW-1:0] period_i,
  input  logic          wrap_i,
  output logic [CW-1:0] duty_act_o,
  output logic [CW-1:0] per_act_o
);

  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] duty_stg_q, per_stg_q;
  logic [CW-1:0] duty_src, per_src, per_norm;

  // Staging pair: last load wins.
  always_ff @(posedge clk) begin
    if (rst) begin
      duty_stg_q <= '0;
      per_stg_q  <= ONE;
    end else if (load_i) begin
      duty_stg_q <= duty_i;
      per_stg_q  <= period_i;
    end
  end

  // A load on the wrap edge bypasses staging so it lands at this boundary.
  always_comb begin
    duty_src = load_i ? duty_i   : duty_stg_q;
    per_src  = load_i ? period_i : per_stg_q;
    per_norm = (per_src == '0) ? ONE : per_src;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      duty_act_o <= '0;
      per_act_o  <= ONE;
    end else if (wrap_i) begin
      duty_act_o <= duty_src;
      per_act_o  <= per_norm;
    end
  end

  // R5: running pair only moves on a boundary edge.
  p_active_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !wrap_i |=> ($stable(duty_act_o) && $stable(per_act_o)));

  // R4: running period is never zero.
  p_period_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
    per_act_o != '0);

endmodule

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr #(
  parameter int unsigned CW = pwm_ratio_pkg::PWM_CW_DEFAULT
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] per_act_i,
  output logic [CW-1:0] cnt_o,
  output logic          wrap_o,
  output logic          start_o
);

  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q;
  logic          start_q;

  assign wrap_o  = (cnt_q == (per_act_i - ONE));
  assign cnt_o   = cnt_q;
  assign start_o = start_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      start_q <= 1'b0;
    end else begin
      cnt_q   <= wrap_o ? '0 : (cnt_q + ONE);
      start_q <= wrap_o;
    end
  end

  // R2: count never reaches the running period.
  p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (rst)
    cnt_q < per_act_i);

  // R2: the start marker only appears with the count at zero.
  p_start_at_zero_r2: assert property (@(posedge clk) disable iff (rst)
    start_q |-> (cnt_q == '0));

  // R1: reset clears the counter and the marker.
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> ((cnt_q == '0) && !start_q));

endmodule

// File: rtl/pwm_level_stage.sv
module pwm_level_stage
  import pwm_ratio_pkg::*;
#(
  parameter int unsigned CW = PWM_CW_DEFAULT
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] duty_act_i,
  input  logic [CW-1:0] per_act_i,
  output logic          pwm_o
);

  pwm_level_e lvl;

  always_comb begin
    if (duty_act_i == '0)              lvl = LVL_LOW;
    else if (duty_act_i >= per_act_i)  lvl = LVL_HIGH;
    else                               lvl = LVL_MOD;
  end

  always_comb begin
    unique case (lvl)
      LVL_LOW:  pwm_o = 1'b0;
      LVL_HIGH: pwm_o = 1'b1;
      default:  pwm_o = (cnt_i < duty_act_i);
    endcase
  end

  // R3: an empty high time never drives the output.
  p_empty_low_r3: assert property (@(posedge clk) disable iff (rst)
    (duty_act_i == '0) |-> !pwm_o);

  // R3: a high time covering the period holds the output high.
  p_full_high_r3: assert property (@(posedge clk) disable iff (rst)
    (duty_act_i >= per_act_i) |-> pwm_o);

  // R3: the last cycle of a period with a partial high time is low.
  p_tail_low_r3: assert property (@(posedge clk) disable iff (rst)
    ((duty_act_i < per_act_i) && (cnt_i == per_act_i - CW'(1))) |-> !pwm_o);

endmodule

// File: rtl/pwm_ratio_gen.sv
module pwm_ratio_gen #(
  parameter int unsigned CW = pwm_ratio_pkg::PWM_CW_DEFAULT
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [CW-1:0] duty_i,
  input  logic [CW-1:0] period_i,
  output logic          pwm_o,
  output logic          period_o
);

  logic [CW-1:0] duty_act, per_act, cnt;
  logic          wrap;

  pwm_cfg_bank #(.CW(CW)) cfg_i (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load_i),
    .duty_i     (duty_i),
    .period_i   (period_i),
    .wrap_i     (wrap),
    .duty_act_o (duty_act),
    .per_act_o  (per_act)
  );

  pwm_period_ctr #(.CW(CW)) ctr_i (
    .clk       (clk),
    .rst       (rst),
    .per_act_i (per_act),
    .cnt_o     (cnt),
    .wrap_o    (wrap),
    .start_o   (period_o)
  );

  pwm_level_stage #(.CW(CW)) lvl_i (
    .clk        (clk),
    .rst        (rst),
    .cnt_i      (cnt),
    .duty_act_i (duty_act),
    .per_act_i  (per_act),
    .pwm_o      (pwm_o)
  );

  // R4: a one-clock period marks every cycle.
  p_unit_period_r4: assert property (@(posedge clk) disable iff (rst)
    ((per_act == CW'(1)) && $past(per_act == CW'(1)) && !$past(rst)) |-> period_o);

endmodule

// File: tb/pwm_ratio_gen_tb_top.sv
module pwm_ratio_gen_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;
  localparam int NV = 10;

  // Each entry: {duty, period}
  localparam logic [15:0] VEC [NV] = '{
    {8'd50,  8'd100}, {8'd50,  8'd101}, {8'd0,   8'd7},  {8'd9,   8'd9},
    {8'd12,  8'd5},   {8'd3,   8'd0},   {8'd1,   8'd1},  {8'd255, 8'd255},
    {8'd4,   8'd16},  {8'd200, 8'd255}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load = 1'b0;
  logic [CW-1:0] duty = '0, per = '0;
  logic pwm, pstart;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_ratio_gen #(.CW(CW)) dut_i (
    .clk(clk), .rst(rst), .load_i(load), .duty_i(duty), .period_i(per),
    .pwm_o(pwm), .period_o(pstart)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_load(input int d, input int p);
    duty = CW'(d); per = CW'(p); load = 1'b1;
    tick();
    load = 1'b0;
    duty = 8'hA5; per = 8'h03; // idle garbage, must be ignored (R8)
  endtask

  task automatic sync_start();
    for (int i = 0; i < 600 && !pstart; i++) tick();
  endtask

  // Walk from cycle index idx to the next period start, checking the waveform.
  task automatic run_period(input int idx, input int exp_per, input int exp_n, input string req);
    int bad = 0;
    int guard = 0;
    do begin
      if (pwm != (idx < exp_n)) bad++;
      idx++;
      tick();
      guard++;
    end while (!pstart && guard < 1000);
    chk({req, " waveform mismatches"}, bad, 0);
    chk({req, " period length"}, idx, exp_per);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    // R1: reset state
    chk("R1 pwm in reset", int'(pwm), 0);
    chk("R1 marker in reset", int'(pstart), 0);
    rst = 1'b0;
    tick();
    // R1/R4: default one-clock period, low level
    chk("R1 default marker", int'(pstart), 1);
    chk("R1 default level", int'(pwm), 0);

    // Vector table: R2, R3, R4
    for (int v = 0; v < NV; v++) begin
      int d = int'(VEC[v][15:8]);
      int p = int'(VEC[v][7:0]);
      int ep = (p == 0) ? 1 : p;
      do_load(d, p);
      sync_start();
      run_period(0, ep, d, (ep == 1) ? "R4" : "R2/R3");
      run_period(0, ep, d, "R8 repeat");
    end

    // R5: mid-period load leaves current period untouched
    do_load(10, 20);
    sync_start();
    run_period(0, 20, 10, "R5 setup");
    for (int i = 0; i < 5; i++) tick();
    do_load(2, 4);
    run_period(6, 20, 10, "R5 current period");
    run_period(0, 4, 2, "R5 next period");

    // R6: load in the last cycle applies immediately
    for (int i = 0; i < 3; i++) tick();
    do_load(3, 7);
    chk("R6 boundary marker", int'(pstart), 1);
    run_period(0, 7, 3, "R6 applied");

    // R7: last of several loads wins
    do_load(1, 5);
    do_load(4, 9);
    run_period(2, 7, 3, "R7 current");
    run_period(0, 9, 4, "R7 last wins");

    // R1: reset mid-run
    rst = 1'b1;
    tick();
    chk("R1 mid-run reset level", int'(pwm), 0);
    chk("R1 mid-run reset marker", int'(pstart), 0);
    rst = 1'b0;
    tick();
    chk("R1 post-reset marker", int'(pstart), 1);
    chk("R1 post-reset level", int'(pwm), 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule